// File: doc/BRIEF.md
# Partitioned SIMD Pixel Arithmetic Unit

This unit performs lane-partitioned integer arithmetic on 64-bit operands for image and video kernels. One datapath carries three kinds of operation. Add and subtract work on independent lanes that wrap at the lane width. Signed compares turn per-lane outcomes into a small integer bit mask. A pack turns signed 16-bit fixed-point lanes into unsigned 8-bit pixels, with a scale shift, rounding and clipping.

A caller presents two sources, an opcode, a lane-width selector, an operand-size bit and a 4-bit scale. It raises `in_valid` for one cycle. The result appears on the next clock edge, together with `out_valid`. The unit has no stall path and accepts a new operation every cycle.

Top module: `pixsimd_unit`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and low otherwise. `result` loads only when `in_valid` is high and holds its value in every other cycle.
- R2: While reset is active, `out_valid` and `result` are zero.
- R3: With `lane32`=0, add (opcode 0) and subtract (opcode 1) act on 16-bit lanes. Each lane wraps modulo 2^16, and no carry or borrow crosses a lane boundary.
- R4: With `lane32`=1, add and subtract act on 32-bit lanes. A carry crosses bit 15 inside a lane but never crosses bit 31. Each lane wraps modulo 2^32.
- R5: With `single`=1, add and subtract use only bits 31:0 of the sources, giving two 16-bit lanes or one 32-bit lane, and `result[63:32]` is zero.
- R6: The compares treat lanes as signed values. Opcode 2 tests a>b, opcode 3 tests a<=b, opcode 4 tests a!=b and opcode 5 tests a==b. They act on four 16-bit lanes (`lane32`=0) or two 32-bit lanes (`lane32`=1), and always on all 64 bits, whatever the value of `single`.
- R7: A compare result holds the bit for lane i at bit i, with lane 0 the least significant lane. All bits above the last lane are zero, so only bits 1:0 can be set in 32-bit mode, even for opcode 3.
- R8: Pack (opcode 6) takes each signed 16-bit lane of `src_b` and shifts it left by `scale`. It then adds 64, which is one at bit 6, just below a binary point at bit 7. It shifts the sum arithmetically right by 7 and clips the value to 0..255.
- R9: Pack places the pixel from lane i in `result[8*i+7:8*i]`, ignores `src_a`, and clears `result[63:32]`.
- R10: Opcode 7 produces a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operation request for this cycle |
| opcode | input | 3 | 0 add, 1 sub, 2 gt, 3 le, 4 ne, 5 eq, 6 pack, 7 none |
| lane32 | input | 1 | 0: 16-bit lanes, 1: 32-bit lanes |
| single | input | 1 | 1: add/sub use only the low 32 bits |
| scale | input | 4 | Left shift applied before pack |
| src_a | input | 64 | First source |
| src_b | input | 64 | Second source (pack input) |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | 64 | Lane results, compare mask or packed pixels |

## Verification
The add and subtract vectors place all-ones and sign-boundary values at lane edges. A carry that leaks between lanes then shows up as a wrong neighbouring lane, and a missing carry inside a 32-bit lane shows up at bit 16. The compare vectors mix negative, equal and extreme lanes, so that signed and unsigned ordering give different masks and each predicate gives a distinct mask. The pack vectors cover values that round up at exactly half, values that stay just below half, values that clip high and low, and a nonzero scale. This separates errors in the shift, the rounding and the clipping.

// File: rtl/pixsimd_pkg.sv
package pixsimd_pkg;
  localparam int DW     = 64;        // datapath width
  localparam int HW     = 16;        // narrow lane width
  localparam int WW     = 2 * HW;    // wide lane width
  localparam int NH     = DW / HW;   // narrow lane count
  localparam int NW     = DW / WW;   // wide lane count
  localparam int PW     = 8;         // pixel width
  localparam int SW     = 4;         // scale width
  localparam int BPOINT = 7;         // binary point of packed fixed value

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_GT   = 3'd2,
    OP_LE   = 3'd3,
    OP_NE   = 3'd4,
    OP_EQ   = 3'd5,
    OP_PACK = 3'd6,
    OP_NONE = 3'd7
  } op_e;
endpackage

// File: rtl/pixsimd_rst_sync.sv
module pixsimd_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end
endmodule

// File: rtl/pixsimd_addsub.sv
module pixsimd_addsub #(
  parameter int DW = 64,
  parameter int HW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  input  logic          lane32,
  input  logic          single,
  output logic [DW-1:0] sum
);
  localparam int NP = DW / (2 * HW);  // 32-bit lane pairs
  localparam int HD = DW / 2;

  logic [DW-1:0] bx;
  logic [DW-1:0] raw;

  assign bx = b ^ {DW{sub}};

  // each pair: low half owns its carry, high half takes it only in wide mode
  for (genvar p = 0; p < NP; p++) begin : g_pair
    logic [HW:0]   lo;
    logic [HW-1:0] hi;
    logic          mid_cin;

    assign lo      = {1'b0, a[2*p*HW +: HW]} + {1'b0, bx[2*p*HW +: HW]} + {{HW{1'b0}}, sub};
    assign mid_cin = lane32 ? lo[HW] : sub;
    assign hi      = a[(2*p+1)*HW +: HW] + bx[(2*p+1)*HW +: HW] + {{(HW-1){1'b0}}, mid_cin};
    assign raw[2*p*HW +: 2*HW] = {hi, lo[HW-1:0]};
  end

  assign sum = single ? {{HD{1'b0}}, raw[HD-1:0]} : raw;
endmodule

// File: rtl/pixsimd_cmp.sv
module pixsimd_cmp
  import pixsimd_pkg::*;
#(
  parameter int DW = 64,
  parameter int HW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          lane32,
  input  op_e           op,
  output logic [DW-1:0] mask
);
  localparam int NN = DW / HW;
  localparam int WL = 2 * HW;
  localparam int NL = DW / WL;

  logic [NN-1:0] gt_n, eq_n;
  logic [NL-1:0] gt_w, eq_w;
  logic [NN-1:0] gt, eq, live, cond;

  for (genvar i = 0; i < NN; i++) begin : g_narrow
    assign gt_n[i] = $signed(a[i*HW +: HW]) > $signed(b[i*HW +: HW]);
    assign eq_n[i] = a[i*HW +: HW] == b[i*HW +: HW];
  end

  for (genvar j = 0; j < NL; j++) begin : g_wide
    assign gt_w[j] = $signed(a[j*WL +: WL]) > $signed(b[j*WL +: WL]);
    assign eq_w[j] = a[j*WL +: WL] == b[j*WL +: WL];
  end

  always_comb begin
    gt   = lane32 ? {{(NN-NL){1'b0}}, gt_w} : gt_n;
    eq   = lane32 ? {{(NN-NL){1'b0}}, eq_w} : eq_n;
    live = lane32 ? {{(NN-NL){1'b0}}, {NL{1'b1}}} : {NN{1'b1}};
    case (op)
      OP_GT:   cond = gt;
      OP_LE:   cond = ~gt;
      OP_NE:   cond = ~eq;
      OP_EQ:   cond = eq;
      default: cond = '0;
    endcase
    mask = {{(DW-NN){1'b0}}, cond & live};
  end
endmodule

// File: rtl/pixsimd_pack.sv
module pixsimd_pack #(
  parameter int DW     = 64,
  parameter int HW     = 16,
  parameter int PW     = 8,
  parameter int SW     = 4,
  parameter int BPOINT = 7
) (
  input  logic [DW-1:0] src,
  input  logic [SW-1:0] scale,
  output logic [DW-1:0] px
);
  localparam int NN   = DW / HW;
  localparam int XW   = HW + (1 << SW) + 2;     // room for the largest shift
  localparam int PMAX = (1 << PW) - 1;

  logic [NN*PW-1:0] bytes;

  for (genvar i = 0; i < NN; i++) begin : g_lane
    logic signed [XW-1:0] ext, shl, rnd, q;

    assign ext = XW'($signed(src[i*HW +: HW]));
    assign shl = ext <<< scale;
    assign rnd = shl + XW'(1 << (BPOINT - 1));
    assign q   = rnd >>> BPOINT;

    always_comb begin
      if (q < 0)
        bytes[i*PW +: PW] = '0;
      else if (q > XW'(PMAX))
        bytes[i*PW +: PW] = PW'(PMAX);
      else
        bytes[i*PW +: PW] = q[PW-1:0];
    end
  end

  assign px = {{(DW-NN*PW){1'b0}}, bytes};
endmodule

// File: rtl/pixsimd_unit.sv
module pixsimd_unit
  import pixsimd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [2:0]    opcode,
  input  logic          lane32,
  input  logic          single,
  input  logic [SW-1:0] scale,
  input  logic [DW-1:0] src_a,
  input  logic [DW-1:0] src_b,
  output logic          out_valid,
  output logic [DW-1:0] result
);
  logic          rst_sync_n;
  op_e           op;
  logic [DW-1:0] as_res, cmp_res, pk_res;
  logic [DW-1:0] res_d;
  logic          vld_d;

  assign op = op_e'(opcode);

  pixsimd_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  pixsimd_addsub #(.DW(DW), .HW(HW)) u_addsub (
    .a      (src_a),
    .b      (src_b),
    .sub    (op == OP_SUB),
    .lane32 (lane32),
    .single (single),
    .sum    (as_res)
  );

  pixsimd_cmp #(.DW(DW), .HW(HW)) u_cmp (
    .a      (src_a),
    .b      (src_b),
    .lane32 (lane32),
    .op     (op),
    .mask   (cmp_res)
  );

  pixsimd_pack #(.DW(DW), .HW(HW), .PW(PW), .SW(SW), .BPOINT(BPOINT)) u_pack (
    .src   (src_b),
    .scale (scale),
    .px    (pk_res)
  );

  // next-state selection
  always_comb begin
    vld_d = in_valid;
    case (op)
      OP_ADD, OP_SUB:             res_d = as_res;
      OP_GT, OP_LE, OP_NE, OP_EQ: res_d = cmp_res;
      OP_PACK:                    res_d = pk_res;
      default:                    res_d = '0;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= vld_d;
      if (in_valid) result <= res_d;
    end
  end
endmodule

// File: rtl/pixsimd_checker.sv
module pixsimd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [2:0]  opcode,
  input logic        lane32,
  input logic        single,
  input logic [63:0] src_a,
  input logic [63:0] src_b,
  input logic        out_valid,
  input logic [63:0] result
);
  p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_valid_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

  p_single_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && single && opcode <= 3'd1) |=> (result[63:32] == 32'h0));

  p_eq_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 3'd5 && !lane32 && src_a == src_b) |=> (result == 64'hF));

  p_mask_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode >= 3'd2 && opcode <= 3'd5) |=> (result[63:4] == 60'h0));

  p_mask_wide_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lane32 && opcode >= 3'd2 && opcode <= 3'd5) |=> (result[3:2] == 2'b00));

  p_pack_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 3'd6) |=> (result[63:32] == 32'h0));

  p_none_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 3'd7) |=> (result == 64'h0));
endmodule

bind pixsimd_unit pixsimd_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .opcode    (opcode),
  .lane32    (lane32),
  .single    (single),
  .src_a     (src_a),
  .src_b     (src_b),
  .out_valid (out_valid),
  .result    (result)
);

// File: tb/pixsimd_unit_bench.sv
`timescale 1ns/1ps
module pixsimd_unit_bench;
  typedef struct packed {
    logic [2:0]  op;
    logic        w;
    logic        s;
    logic [3:0]  sc;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] e;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 1'b0, 1'b0, 4'd0, 64'h0001_7FFF_FFFF_0010, 64'h0001_0001_0001_0020, 64'h0002_8000_0000_0030}, // R3
    '{3'd1, 1'b0, 1'b0, 4'd0, 64'h0000_0005_8000_0003, 64'h0001_0003_0001_0005, 64'hFFFF_0002_7FFF_FFFE}, // R3
    '{3'd0, 1'b1, 1'b0, 4'd0, 64'h7FFF_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, 64'h8000_0000_0001_0000}, // R4
    '{3'd1, 1'b1, 1'b0, 4'd0, 64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF}, // R4
    '{3'd0, 1'b0, 1'b1, 4'd0, 64'h1234_5678_0001_FFFF, 64'hFFFF_FFFF_0001_0001, 64'h0000_0000_0002_0000}, // R5
    '{3'd1, 1'b1, 1'b1, 4'd0, 64'hAAAA_AAAA_0000_0010, 64'h5555_5555_0000_0020, 64'h0000_0000_FFFF_FFF0}, // R5
    '{3'd2, 1'b0, 1'b0, 4'd0, 64'h8000_0005_0003_FFFF, 64'h7FFF_0005_0001_0000, 64'h0000_0000_0000_0002}, // R6
    '{3'd3, 1'b0, 1'b0, 4'd0, 64'h8000_0005_0003_FFFF, 64'h7FFF_0005_0001_0000, 64'h0000_0000_0000_000D}, // R6
    '{3'd4, 1'b0, 1'b0, 4'd0, 64'h8000_0005_0003_FFFF, 64'h7FFF_0005_0001_0000, 64'h0000_0000_0000_000B}, // R6
    '{3'd5, 1'b0, 1'b0, 4'd0, 64'h8000_0005_0003_FFFF, 64'h7FFF_0005_0001_0000, 64'h0000_0000_0000_0004}, // R6
    '{3'd2, 1'b1, 1'b0, 4'd0, 64'h0000_0001_FFFF_FFFF, 64'hFFFF_FFFF_0000_0000, 64'h0000_0000_0000_0002}, // R6
    '{3'd5, 1'b1, 1'b1, 4'd0, 64'h1234_0000_0000_0008, 64'h1235_0000_0000_0008, 64'h0000_0000_0000_0001}, // R6
    '{3'd6, 1'b0, 1'b0, 4'd0, 64'hDEAD_BEEF_DEAD_BEEF, 64'h01C0_FF00_7FFF_0080, 64'h0000_0000_0400_FF01}, // R8
    '{3'd6, 1'b0, 1'b0, 4'd4, 64'hDEAD_BEEF_DEAD_BEEF, 64'h0004_0C00_0100_0008, 64'h0000_0000_01FF_2001}, // R8
    '{3'd6, 1'b1, 1'b1, 4'd0, 64'h0123_4567_89AB_CDEF, 64'h7F80_8000_0040_003F, 64'h0000_0000_FF00_0100}, // R8
    '{3'd7, 1'b0, 1'b0, 4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000}  // R10
  };

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  opcode;
  logic        lane32;
  logic        single;
  logic [3:0]  scale;
  logic [63:0] src_a;
  logic [63:0] src_b;
  logic        out_valid;
  logic [63:0] result;

  int checks;
  int fails;
  int cycles;
  logic [63:0] held;

  pixsimd_unit u_pixsimd_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .opcode    (opcode),
    .lane32    (lane32),
    .single    (single),
    .scale     (scale),
    .src_a     (src_a),
    .src_b     (src_b),
    .out_valid (out_valid),
    .result    (result)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired: actual %0d cycles expected below 100000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  function automatic string req_of(vec_t v);
    if (v.op <= 3'd1) return v.s ? "R5" : (v.w ? "R4" : "R3");
    if (v.op <= 3'd5) return "R6";
    if (v.op == 3'd6) return "R8";
    return "R10";
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(vec_t v);
    @(negedge clk);
    in_valid = 1'b1;
    opcode   = v.op;
    lane32   = v.w;
    single   = v.s;
    scale    = v.sc;
    src_a    = v.a;
    src_b    = v.b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    checks   = 0;
    fails    = 0;
    cycles   = 0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    opcode   = 3'd0;
    lane32   = 1'b0;
    single   = 1'b0;
    scale    = 4'd0;
    src_a    = '0;
    src_b    = '0;
    repeat (3) @(negedge clk);
    // R2: reset state
    check("R2 out_valid", {63'b0, out_valid}, 64'h0);
    check("R2 result", result, 64'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i]);
      check(req_of(VEC[i]), result, VEC[i].e);
    end

    // R1: valid latency and hold with changing idle inputs
    issue(VEC[0]);
    check("R1 out_valid high", {63'b0, out_valid}, 64'h1);
    held   = result;
    opcode = 3'd7;
    src_a  = 64'h5555_5555_5555_5555;
    @(negedge clk);
    check("R1 out_valid low", {63'b0, out_valid}, 64'h0);
    check("R1 result held", result, held);

    // R7: wide-lane less-or-equal sets only bits 1:0
    issue('{3'd3, 1'b1, 1'b0, 4'd0, 64'h0, 64'h0, 64'h0});
    check("R7 wide le mask", result, 64'h3);
    // R7: narrow not-equal on all lanes gives 4 bits, lane 0 in bit 0
    issue('{3'd4, 1'b0, 1'b0, 4'd0, 64'h0000_0000_0000_0001, 64'h0, 64'h0});
    check("R7 lane0 bit0", result, 64'h1);

    // R9: src_a ignored by pack, upper half cleared
    issue('{3'd6, 1'b0, 1'b0, 4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0100_0080_0000_7FFF, 64'h0});
    check("R9 pack placement", result, 64'h0000_0000_0201_00FF);
    issue('{3'd6, 1'b0, 1'b0, 4'd0, 64'h0, 64'h0100_0080_0000_7FFF, 64'h0});
    check("R9 pack ignores src_a", result, 64'h0000_0000_0201_00FF);

    // R8: negative lane with large scale clips to zero, max scale on small value
    issue('{3'd6, 1'b0, 1'b0, 4'd15, 64'h0, 64'h0000_0001_FFFF_0000, 64'h0});
    check("R8 scale 15", result, 64'h0000_0000_00FF_0000);

    // R2: reset mid-run clears result
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R2 reset again", result, 64'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule